// File: doc/BRIEF.md
# Hart Status Register with Aliased Access Views

This block holds the 64-bit machine-level status word of a processor hart. The register stores the interrupt enables, the saved enables and saved privilege levels used on trap return, the floating-point and extension context states, the memory-access modifiers and the trap-control bits. It also holds the two read-only width codes for the lower privilege levels.

A single physical register is reachable through three access views: machine, supervisor and user. Each view has its own read mask and its own write mask, and the two narrower views keep no storage of their own. A CSR port applies write, set-bits and clear-bits operations through the view that is selected and returns combinational read data masked for that view.

A second port stages single-field updates into a value buffer and a mask buffer. A commit pulse then folds all staged fields into the register in one masked merge. Decoded field outputs feed the trap, interrupt and translation logic of the hart.

Top module: `hart_status_reg`

## Requirements
- R1: Reset loads the parameter XLEN_RESET (default 2) into bits 33:32 and into bits 35:34, and every other bit loads 0. With the default parameters a machine-view read returns 0x0000_000A_0000_0000 after reset.
- R2: The machine view (csr_view=0) reads through mask 0x8000_000F_007F_F9BB and writes through mask 0x0000_0000_007F_F9BB. A stored bit outside the write mask never changes.
- R3: The supervisor view (csr_view=1) reads through mask 0x8000_0003_000D_E133 and writes through mask 0x0000_0000_000D_E133, acting on the same stored bits as the machine view.
- R4: The user view (csr_view=2) reads and writes only bit 0 and bit 4, using mask 0x11.
- R5: csr_op=0 writes csr_wdata, csr_op=1 ORs csr_wdata in, and csr_op=2 clears the bits that are set in csr_wdata. Each operation acts only inside the write mask of the selected view.
- R6: With csr_view=3 the read data is 0 and writes are ignored. csr_op=3 reads without changing the register. When csr_en is low nothing is written.
- R7: A CSR write or a commit that would place the value 2 in bits 12:11 (the machine saved privilege) leaves those two bits unchanged, while the other written bits still update.
- R8: stage_en writes stage_value into the buffered field selected by stage_field. The field codes and their bit positions are: 0 bit 0, 1 bit 1, 2 bit 3, 3 bit 4, 4 bit 5, 5 bit 7, 6 bit 8, 7 bits 12:11, 8 bits 14:13, 9 bits 16:15, 10 bit 17, 11 bit 18, 12 bit 19, 13 bit 20, 14 bit 21, 15 bit 22. When the same field is staged twice, the later value wins. commit writes (current AND NOT mask) OR value through the machine write mask and then clears both buffers. A field staged in the same cycle as a commit goes into the next batch.
- R9: When a CSR write and a commit fall in the same cycle, the commit merge is applied on top of the result of the CSR write.
- R10: Each decoded field output equals its stored bits. The dirty-summary output equals bit 31 OR bit 63. Because neither of those bits is writable, it stays 0.
- R11: An update becomes visible on csr_rdata and on the decoded outputs only after the next rising clock edge. csr_rdata follows csr_view combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | CSR operation strobe |
| csr_view | input | 2 | 0 machine, 1 supervisor, 2 user, 3 none |
| csr_op | input | 2 | 0 write, 1 set bits, 2 clear bits, 3 read only |
| csr_wdata | input | 64 | CSR operand |
| csr_rdata | output | 64 | Register masked by the selected view's read mask |
| stage_en | input | 1 | Stage one field update |
| stage_field | input | 4 | Field code to stage |
| stage_value | input | 2 | Field value (LSB only for one-bit fields) |
| commit | input | 1 | Merge staged fields and clear the buffers |
| ie_user | output | 1 | User interrupt enable (bit 0) |
| ie_sup | output | 1 | Supervisor interrupt enable (bit 1) |
| ie_mach | output | 1 | Machine interrupt enable (bit 3) |
| pie_user | output | 1 | User saved enable (bit 4) |
| pie_sup | output | 1 | Supervisor saved enable (bit 5) |
| pie_mach | output | 1 | Machine saved enable (bit 7) |
| prev_priv_sup | output | 1 | Supervisor saved privilege (bit 8) |
| prev_priv_mach | output | 2 | Machine saved privilege (bits 12:11) |
| fp_state | output | 2 | Floating-point context state (bits 14:13) |
| ext_state | output | 2 | Extension context state (bits 16:15) |
| priv_modify | output | 1 | Load/store privilege override (bit 17) |
| user_mem_ok | output | 1 | Supervisor access to user pages (bit 18) |
| exec_as_read | output | 1 | Executable pages readable (bit 19) |
| trap_vm | output | 1 | Trap translation management (bit 20) |
| trap_wait | output | 1 | Trap wait-for-interrupt (bit 21) |
| trap_sup_ret | output | 1 | Trap supervisor return (bit 22) |
| user_xlen | output | 2 | User width code (bits 33:32) |
| sup_xlen | output | 2 | Supervisor width code (bits 35:34) |
| dirty_summary | output | 1 | Bit 31 OR bit 63 |

## Verification
The bench builds the block with its default parameters: the user view is present and the reset width code is 2. This puts all three views within reach, including the user view's two-bit window and the reset value 0xA in bits 35:32 seen through each read mask. A bench-side model replays every operation against the masks and field codes in the requirements. This covers same-cycle commit and CSR write, restaging a field, staging in the commit cycle, and attempts to store the reserved saved-privilege code through either path.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  localparam int XW = 64;

  localparam logic [XW-1:0] MACH_RD = 64'h8000_000F_007F_F9BB;
  localparam logic [XW-1:0] MACH_WR = 64'h0000_0000_007F_F9BB;
  localparam logic [XW-1:0] SUP_RD  = 64'h8000_0003_000D_E133;
  localparam logic [XW-1:0] SUP_WR  = 64'h0000_0000_000D_E133;
  localparam logic [XW-1:0] USR_RD  = 64'h0000_0000_0000_0011;
  localparam logic [XW-1:0] USR_WR  = 64'h0000_0000_0000_0011;

  localparam int PP_LO = 11;
  localparam logic [1:0] PP_RESERVED = 2'b10;

  typedef enum logic [1:0] {
    VIEW_MACH = 2'd0,
    VIEW_SUP  = 2'd1,
    VIEW_USR  = 2'd2,
    VIEW_NONE = 2'd3
  } view_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  function automatic logic [XW-1:0] read_mask(input logic [1:0] v, input bit has_usr);
    case (v)
      VIEW_MACH: read_mask = MACH_RD;
      VIEW_SUP:  read_mask = SUP_RD;
      VIEW_USR:  read_mask = has_usr ? USR_RD : '0;
      default:   read_mask = '0;
    endcase
  endfunction

  function automatic logic [XW-1:0] write_mask(input logic [1:0] v, input bit has_usr);
    case (v)
      VIEW_MACH: write_mask = MACH_WR;
      VIEW_SUP:  write_mask = SUP_WR;
      VIEW_USR:  write_mask = has_usr ? USR_WR : '0;
      default:   write_mask = '0;
    endcase
  endfunction

  // Raw result of a CSR operation before the view mask is applied.
  function automatic logic [XW-1:0] op_result(input logic [1:0] op,
                                              input logic [XW-1:0] cur,
                                              input logic [XW-1:0] data);
    case (op)
      OP_WRITE: op_result = data;
      OP_SET:   op_result = cur | data;
      OP_CLEAR: op_result = cur & ~data;
      default:  op_result = cur;
    endcase
  endfunction

  // Masked merge that refuses the reserved saved-privilege code.
  function automatic logic [XW-1:0] guarded_merge(input logic [XW-1:0] old_v,
                                                  input logic [XW-1:0] new_v,
                                                  input logic [XW-1:0] wm);
    logic [XW-1:0] t;
    t = (old_v & ~wm) | (new_v & wm);
    if (t[PP_LO +: 2] == PP_RESERVED) t[PP_LO +: 2] = old_v[PP_LO +: 2];
    return t;
  endfunction

  function automatic logic [5:0] field_lsb(input logic [3:0] f);
    case (f)
      4'd0:  field_lsb = 6'd0;
      4'd1:  field_lsb = 6'd1;
      4'd2:  field_lsb = 6'd3;
      4'd3:  field_lsb = 6'd4;
      4'd4:  field_lsb = 6'd5;
      4'd5:  field_lsb = 6'd7;
      4'd6:  field_lsb = 6'd8;
      4'd7:  field_lsb = 6'd11;
      4'd8:  field_lsb = 6'd13;
      4'd9:  field_lsb = 6'd15;
      4'd10: field_lsb = 6'd17;
      4'd11: field_lsb = 6'd18;
      4'd12: field_lsb = 6'd19;
      4'd13: field_lsb = 6'd20;
      4'd14: field_lsb = 6'd21;
      default: field_lsb = 6'd22;
    endcase
  endfunction

  function automatic logic field_is_pair(input logic [3:0] f);
    return (f == 4'd7) || (f == 4'd8) || (f == 4'd9);
  endfunction

endpackage

// File: rtl/hsr_stage_buf.sv
module hsr_stage_buf
  import hsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_en,
  input  logic [3:0]    stage_field,
  input  logic [1:0]    stage_value,
  input  logic          commit,
  output logic [XW-1:0] buf_val,
  output logic [XW-1:0] buf_mask
);

  logic [XW-1:0] fld_mask;
  logic [XW-1:0] fld_val;
  logic [XW-1:0] base_val;
  logic [XW-1:0] base_mask;
  logic [XW-1:0] nxt_val;
  logic [XW-1:0] nxt_mask;

  always_comb begin
    fld_mask  = (field_is_pair(stage_field) ? 64'h3 : 64'h1) << field_lsb(stage_field);
    fld_val   = ({62'b0, stage_value} << field_lsb(stage_field)) & fld_mask;
    base_val  = commit ? '0 : buf_val;
    base_mask = commit ? '0 : buf_mask;
    nxt_val   = base_val;
    nxt_mask  = base_mask;
    if (stage_en) begin
      nxt_val  = (base_val & ~fld_mask) | fld_val;
      nxt_mask = base_mask | fld_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_val  <= '0;
      buf_mask <= '0;
    end else begin
      buf_val  <= nxt_val;
      buf_mask <= nxt_mask;
    end
  end

  AST_BUF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !stage_en |=> buf_mask == '0); // R8
  AST_LAST_STAGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en |=> (buf_val & $past(fld_mask)) == $past(fld_val)); // R8

endmodule

// File: rtl/hsr_update_path.sv
module hsr_update_path
  import hsr_pkg::*;
#(
  parameter bit HAS_USR_VIEW = 1'b1
) (
  input  logic [XW-1:0] cur,
  input  logic          csr_en,
  input  logic [1:0]    csr_view,
  input  logic [1:0]    csr_op,
  input  logic [XW-1:0] csr_wdata,
  input  logic          commit,
  input  logic [XW-1:0] buf_val,
  input  logic [XW-1:0] buf_mask,
  output logic          csr_hit,
  output logic [XW-1:0] after_csr,
  output logic [XW-1:0] nxt
);

  logic [XW-1:0] view_wm;
  logic [XW-1:0] staged;

  always_comb begin
    view_wm   = write_mask(csr_view, HAS_USR_VIEW);
    csr_hit   = csr_en && (csr_op != OP_READ) && (view_wm != '0);
    after_csr = csr_hit ? guarded_merge(cur, op_result(csr_op, cur, csr_wdata), view_wm)
                        : cur;
    staged    = (after_csr & ~buf_mask) | buf_val;
    nxt       = commit ? guarded_merge(after_csr, staged, MACH_WR) : after_csr;
  end

endmodule

// File: rtl/hart_status_reg.sv
module hart_status_reg
  import hsr_pkg::*;
#(
  parameter logic [1:0] XLEN_RESET   = 2'd2,
  parameter bit         HAS_USR_VIEW = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_en,
  input  logic [1:0]  csr_view,
  input  logic [1:0]  csr_op,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  input  logic        stage_en,
  input  logic [3:0]  stage_field,
  input  logic [1:0]  stage_value,
  input  logic        commit,
  output logic        ie_user,
  output logic        ie_sup,
  output logic        ie_mach,
  output logic        pie_user,
  output logic        pie_sup,
  output logic        pie_mach,
  output logic        prev_priv_sup,
  output logic [1:0]  prev_priv_mach,
  output logic [1:0]  fp_state,
  output logic [1:0]  ext_state,
  output logic        priv_modify,
  output logic        user_mem_ok,
  output logic        exec_as_read,
  output logic        trap_vm,
  output logic        trap_wait,
  output logic        trap_sup_ret,
  output logic [1:0]  user_xlen,
  output logic [1:0]  sup_xlen,
  output logic        dirty_summary
);

  localparam logic [XW-1:0] RESET_VAL = {28'b0, XLEN_RESET, XLEN_RESET, 32'b0};

  logic [XW-1:0] q;
  logic [XW-1:0] buf_val;
  logic [XW-1:0] buf_mask;
  logic          csr_hit;
  logic [XW-1:0] after_csr;
  logic [XW-1:0] nxt;

  hsr_stage_buf u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_en    (stage_en),
    .stage_field (stage_field),
    .stage_value (stage_value),
    .commit      (commit),
    .buf_val     (buf_val),
    .buf_mask    (buf_mask)
  );

  hsr_update_path #(.HAS_USR_VIEW(HAS_USR_VIEW)) u_path (
    .cur       (q),
    .csr_en    (csr_en),
    .csr_view  (csr_view),
    .csr_op    (csr_op),
    .csr_wdata (csr_wdata),
    .commit    (commit),
    .buf_val   (buf_val),
    .buf_mask  (buf_mask),
    .csr_hit   (csr_hit),
    .after_csr (after_csr),
    .nxt       (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= nxt;
  end

  assign csr_rdata = q & read_mask(csr_view, HAS_USR_VIEW);

  assign ie_user        = q[0];
  assign ie_sup         = q[1];
  assign ie_mach        = q[3];
  assign pie_user       = q[4];
  assign pie_sup        = q[5];
  assign pie_mach       = q[7];
  assign prev_priv_sup  = q[8];
  assign prev_priv_mach = q[12:11];
  assign fp_state       = q[14:13];
  assign ext_state      = q[16:15];
  assign priv_modify    = q[17];
  assign user_mem_ok    = q[18];
  assign exec_as_read   = q[19];
  assign trap_vm        = q[20];
  assign trap_wait      = q[21];
  assign trap_sup_ret   = q[22];
  assign user_xlen      = q[33:32];
  assign sup_xlen       = q[35:34];
  assign dirty_summary  = q[31] | q[63];

  AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q ^ $past(q)) & ~MACH_WR) == '0); // R2
  AST_SUP_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_en && csr_view == VIEW_SUP && !commit |=> ((q ^ $past(q)) & ~SUP_WR) == '0); // R3
  AST_USR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_en && csr_view == VIEW_USR && !commit |=> ((q ^ $past(q)) & ~USR_WR) == '0); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit && !commit |=> $stable(q)); // R6
  AST_PP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    prev_priv_mach != PP_RESERVED); // R7
  AST_COMMIT_OVER_CSR: assert property (@(posedge clk) disable iff (!rst_n)
    commit && csr_hit |=> ((q ^ $past(after_csr)) & ~$past(buf_mask)) == '0); // R9
  AST_DIRTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dirty_summary); // R10

endmodule

// File: tb/hart_status_reg_tb.sv
module hart_status_reg_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 1'b0;
  logic [1:0]  csr_view = 2'd0;
  logic [1:0]  csr_op = 2'd3;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        stage_en = 1'b0;
  logic [3:0]  stage_field = '0;
  logic [1:0]  stage_value = '0;
  logic        commit = 1'b0;
  logic ie_user, ie_sup, ie_mach, pie_user, pie_sup, pie_mach, prev_priv_sup;
  logic [1:0] prev_priv_mach, fp_state, ext_state, user_xlen, sup_xlen;
  logic priv_modify, user_mem_ok, exec_as_read, trap_vm, trap_wait, trap_sup_ret;
  logic dirty_summary;

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_view(csr_view), .csr_op(csr_op),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .stage_en(stage_en),
    .stage_field(stage_field), .stage_value(stage_value), .commit(commit),
    .ie_user(ie_user), .ie_sup(ie_sup), .ie_mach(ie_mach), .pie_user(pie_user),
    .pie_sup(pie_sup), .pie_mach(pie_mach), .prev_priv_sup(prev_priv_sup),
    .prev_priv_mach(prev_priv_mach), .fp_state(fp_state), .ext_state(ext_state),
    .priv_modify(priv_modify), .user_mem_ok(user_mem_ok), .exec_as_read(exec_as_read),
    .trap_vm(trap_vm), .trap_wait(trap_wait), .trap_sup_ret(trap_sup_ret),
    .user_xlen(user_xlen), .sup_xlen(sup_xlen), .dirty_summary(dirty_summary)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [63:0] exp; } item_t;
  item_t sb_q[$];

  // Bench model
  logic [63:0] m;
  logic [63:0] bv, bm;

  function automatic logic [63:0] b_wmask(input logic [1:0] v);
    if (v == 2'd0) return 64'h7F_F9BB;
    if (v == 2'd1) return 64'hD_E133;
    if (v == 2'd2) return 64'h11;
    return 64'h0;
  endfunction

  function automatic logic [63:0] b_rmask(input logic [1:0] v);
    if (v == 2'd0) return 64'h8000_000F_007F_F9BB;
    if (v == 2'd1) return 64'h8000_0003_000D_E133;
    if (v == 2'd2) return 64'h11;
    return 64'h0;
  endfunction

  function automatic logic [63:0] b_store(input logic [63:0] o, input logic [63:0] n,
                                          input logic [63:0] wm);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = wm[i] ? n[i] : o[i];
    if (r[12] == 1'b1 && r[11] == 1'b0) begin r[12] = o[12]; r[11] = o[11]; end
    return r;
  endfunction

  function automatic void b_field(input logic [3:0] f, output int lo, output int w);
    int los[16] = '{0, 1, 3, 4, 5, 7, 8, 11, 13, 15, 17, 18, 19, 20, 21, 22};
    lo = los[f];
    w = (f >= 4'd7 && f <= 4'd9) ? 2 : 1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data and compares
  always @(negedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, csr_rdata, it.exp);
    end
  end

  task automatic probe(input logic [1:0] v, input string tag);
    item_t it;
    @(negedge clk);
    csr_en = 1'b0; stage_en = 1'b0; commit = 1'b0;
    csr_view = v;
    it.tag = tag;
    it.exp = m & b_rmask(v);
    sb_q.push_back(it);
  endtask

  task automatic step(input logic en, input logic [1:0] v, input logic [1:0] op,
                      input logic [63:0] d, input logic st, input logic [3:0] f,
                      input logic [1:0] val, input logic cm);
    logic [63:0] r, n;
    int lo, w;
    @(negedge clk);
    csr_en = en; csr_view = v; csr_op = op; csr_wdata = d;
    stage_en = st; stage_field = f; stage_value = val; commit = cm;
    r = m;
    if (en && op != 2'd3 && v != 2'd3) begin
      if (op == 2'd0) n = d; else if (op == 2'd1) n = r | d; else n = r & ~d;
      r = b_store(r, n, b_wmask(v));
    end
    if (cm) begin
      r = b_store(r, (r & ~bm) | bv, 64'h7F_F9BB);
      bv = '0; bm = '0;
    end
    if (st) begin
      logic [63:0] fm;
      b_field(f, lo, w);
      fm = ((w == 2) ? 64'h3 : 64'h1) << lo;
      bm = bm | fm;
      bv = (bv & ~fm) | (({62'b0, val} << lo) & fm);
    end
    m = r;
    @(negedge clk);
    csr_en = 1'b0; stage_en = 1'b0; commit = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m = 64'h0000_000A_0000_0000; bv = '0; bm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset value through each view
    probe(2'd0, "R1 machine reset");
    probe(2'd1, "R1 supervisor reset");
    probe(2'd2, "R1 user reset");
    @(negedge clk); #2;
    check("R1 user_xlen", {62'b0, user_xlen}, 64'd2);
    check("R1 sup_xlen", {62'b0, sup_xlen}, 64'd2);
    // R2 machine write of all ones
    step(1, 2'd0, 2'd0, '1, 0, 0, 0, 0);
    probe(2'd0, "R2 machine all ones");
    probe(2'd1, "R3 supervisor sees shared bits");
    probe(2'd2, "R4 user sees bits 0 and 4");
    @(negedge clk); #2;
    check("R10 dirty summary low", {63'b0, dirty_summary}, 64'd0);
    // R3 supervisor clear
    step(1, 2'd1, 2'd2, '1, 0, 0, 0, 0);
    probe(2'd0, "R3 supervisor clear");
    // R4 user write
    step(1, 2'd2, 2'd0, '1, 0, 0, 0, 0);
    probe(2'd0, "R4 user write");
    // R5 set and clear
    step(1, 2'd0, 2'd1, 64'h0000_0000_0000_6008, 0, 0, 0, 0);
    probe(2'd0, "R5 set bits");
    step(1, 2'd0, 2'd2, 64'hFFFF_0000_0000_0011, 0, 0, 0, 0);
    probe(2'd0, "R5 clear bits");
    // R6 no-view write and read-only op
    step(1, 2'd3, 2'd0, '0, 0, 0, 0, 0);
    probe(2'd0, "R6 view none ignored");
    probe(2'd3, "R6 view none reads zero");
    step(1, 2'd0, 2'd3, '0, 0, 0, 0, 0);
    probe(2'd0, "R6 read op no change");
    // R7 reserved saved privilege via CSR
    step(1, 2'd0, 2'd0, 64'h0000_0000_0000_1002, 0, 0, 0, 0);
    probe(2'd0, "R7 reserved via csr");
    // R11 update not visible before the edge
    @(negedge clk);
    csr_view = 2'd0; csr_en = 1'b1; csr_op = 2'd0; csr_wdata = 64'h0000_0000_0040_0000;
    #1;
    check("R11 no change before edge", csr_rdata, m & b_rmask(2'd0));
    @(negedge clk);
    csr_en = 1'b0;
    m = b_store(m, 64'h0000_0000_0040_0000, b_wmask(2'd0));
    probe(2'd0, "R11 visible after edge");
    // R8 staging, last wins, commit
    step(0, 2'd0, 2'd3, '0, 1, 4'd8, 2'd3, 0);
    step(0, 2'd0, 2'd3, '0, 1, 4'd8, 2'd1, 0);
    step(0, 2'd0, 2'd3, '0, 1, 4'd2, 2'd1, 0);
    step(0, 2'd0, 2'd3, '0, 1, 4'd14, 2'd1, 1);
    probe(2'd0, "R8 commit merges last staged");
    step(0, 2'd0, 2'd3, '0, 0, 0, 0, 1);
    probe(2'd0, "R8 field staged in commit cycle");
    // R9 commit over CSR write
    step(0, 2'd0, 2'd3, '0, 1, 4'd1, 2'd1, 0);
    step(0, 2'd0, 2'd3, '0, 1, 4'd9, 2'd2, 0);
    step(1, 2'd0, 2'd0, 64'h0000_0000_0000_0180, 0, 0, 0, 1);
    probe(2'd0, "R9 commit on top of csr write");
    // R7 reserved saved privilege via commit
    step(0, 2'd0, 2'd3, '0, 1, 4'd7, 2'd3, 1);
    step(0, 2'd0, 2'd3, '0, 1, 4'd7, 2'd2, 0);
    step(0, 2'd0, 2'd3, '0, 1, 4'd15, 2'd1, 1);
    probe(2'd0, "R7 reserved via commit");
    // R10 decoded outputs
    @(negedge clk); #2;
    check("R10 decoded low fields",
          {56'b0, pie_mach, 1'b0, pie_sup, pie_user, ie_mach, 1'b0, ie_sup, ie_user},
          {56'b0, m[7:0] & 8'hBB});
    check("R10 decoded mid fields",
          {48'b0, trap_sup_ret, trap_wait, trap_vm, exec_as_read, user_mem_ok, priv_modify,
           ext_state, fp_state, prev_priv_mach, prev_priv_sup},
          {48'b0, m[22:11], m[8]});
    check("R10 dirty summary", {63'b0, dirty_summary}, {63'b0, m[31] | m[63]});
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule